// File: doc/BRIEF.md
# Camera Line Capture Buffer

This block takes parallel pixel words from a deserialized camera link and stores them in a 2048-word two-port buffer. A host reads them back through a small register port. The camera side delivers a 32-bit word per camera clock, qualified by frame-valid, line-valid and data-valid. Horizontal and vertical sync are also brought in and reported to the host.

The host arms a capture with a start command. The capture engine then waits for the next rising edge of frame-valid. From then on it stores one word in each camera clock in which all three qualifiers and both enables are high. It stops at the end of the frame or when the buffer is full. Either event raises a done flag and, if enabled, an interrupt. The host drains the words by repeatedly reading the data register. Each read returns the word at the host pointer and moves that pointer on. A status word reports the host pointer, the camera write pointer, the flags and the live qualifiers.

The camera side runs on its own clock. Only Gray-coded write counts and synchronized levels or toggles pass between the two domains.

Top module: `line_capture_buf`

## Requirements
- R1: The command register (address 0) holds enable in bit 0, data enable in bit 2 and interrupt enable in bit 3, and reads them back. All three are 0 after reset. The clear bit (bit 1) and the start bit (bit 4) always read 0.
- R2: Writing 1 to command bit 1 clears the host pointer, the camera write pointer, the done flag and the interrupt flag.
- R3: A start command arms the capture. No word is stored until frame-valid next rises, so a frame already in progress when start arrives is skipped.
- R4: While a capture runs, one word is stored per camera clock in which frame-valid, line-valid, data-valid, enable and data enable are all 1. Words are stored at consecutive addresses in arrival order, and nothing is stored if data enable is 0.
- R5: The fall of frame-valid ends a running capture and sets done (status bit 11).
- R6: Storing the word at address 2047 ends the capture and sets done. Later valid words in the same frame are dropped, and the write pointer field reads 0 with 2048 words unread.
- R7: When done rises with interrupt enable set, the interrupt flag (status bit 15) and irq_o go to 1. They stay 0 when interrupt enable is 0. The flag is cleared by a start or clear command.
- R8: Data ready (status bit 12) is 1 exactly when captured words remain unread by the host.
- R9: A read of the data register (address 2) returns the word at the host pointer and advances the pointer by one. A read with no unread words leaves the pointer unchanged.
- R10: Status bits 14, 13, 29, 30 and 31 show the synchronized frame-valid, line-valid, data-valid, horizontal sync and vertical sync inputs. Bits 27 and 28 read 0.
- R11: The status register (address 1) gives the host pointer in bits 10:0 and the camera write pointer in bits 26:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Host domain asynchronous reset, active low |
| reg_addr_i | input | 2 | Register select: 0 command, 1 status, 2 data |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe; advances the host pointer on a data read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on the address |
| irq_o | output | 1 | Interrupt request |
| cam_clk_i | input | 1 | Camera pixel clock |
| cam_rst_ni | input | 1 | Camera domain asynchronous reset, active low |
| cam_data_i | input | 32 | Pixel word |
| cam_fv_i | input | 1 | Frame valid |
| cam_lv_i | input | 1 | Line valid |
| cam_dv_i | input | 1 | Data valid |
| cam_hs_i | input | 1 | Horizontal sync |
| cam_vs_i | input | 1 | Vertical sync |

## Verification
The critical overlap is a host data read that advances the host pointer in the same host cycle in which a newly synchronized camera write count arrives. Both change the data-ready comparison at once. The bench provokes this by draining the buffer while a 2100-pixel line is still being captured, polling data ready and reading whenever it is set. Every word is compared in order against the scoreboard queue. At the end, data ready must be 0 with both pointer fields at 0, which shows that no word was skipped or read twice and that the writes beyond address 2047 were dropped.

// File: rtl/lcb_pkg.sv
`timescale 1ns/1ps
package lcb_pkg;
  typedef enum logic [1:0] {CAP_IDLE, CAP_ARMED, CAP_RUN, CAP_DONE} cap_state_e;

  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;

  localparam int CMD_EN    = 0;
  localparam int CMD_CLR   = 1;
  localparam int CMD_DEN   = 2;
  localparam int CMD_IEN   = 3;
  localparam int CMD_START = 4;
endpackage

// File: rtl/lcb_sync.sv
`timescale 1ns/1ps
module lcb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lcb_dpram.sv
`timescale 1ns/1ps
module lcb_dpram #(
  parameter int DW = 32,
  parameter int AW = 11
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // host only addresses words already published through the synced count
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lcb_cam_ctrl.sv
`timescale 1ns/1ps
module lcb_cam_ctrl
  import lcb_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          den_i,
  input  logic          start_tgl_i,
  input  logic          clr_tgl_i,
  input  logic          fv_i,
  input  logic          lv_i,
  input  logic          dv_i,
  input  logic [DW-1:0] data_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic [AW:0]   wr_gray_o,
  output logic          done_o
);
  localparam int CW = AW + 1;

  cap_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, gray_q;
  logic          done_q, done_d;
  logic          start_q, clr_q, fv_q;
  logic          start_p, clr_p, fv_rise, pix_ok;

  assign start_p = start_tgl_i ^ start_q;
  assign clr_p   = clr_tgl_i ^ clr_q;
  assign fv_rise = fv_i & ~fv_q;
  assign pix_ok  = en_i & den_i & lv_i & dv_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    we_o    = 1'b0;
    if (clr_p) begin
      state_d = CAP_IDLE;
      cnt_d   = '0;
      done_d  = 1'b0;
    end else begin
      unique case (state_q)
        CAP_IDLE, CAP_DONE: if (start_p) begin
          state_d = CAP_ARMED;
          done_d  = 1'b0;
        end
        CAP_ARMED: if (fv_rise) state_d = CAP_RUN;
        CAP_RUN: begin
          if (!fv_i) begin
            state_d = CAP_DONE;
            done_d  = 1'b1;
          end else if (pix_ok) begin
            we_o  = 1'b1;
            cnt_d = cnt_q + 1'b1;
            if (&cnt_q[AW-1:0]) begin
              state_d = CAP_DONE;
              done_d  = 1'b1;
            end
          end
        end
        default: state_d = CAP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CAP_IDLE;
      cnt_q   <= '0;
      gray_q  <= '0;
      done_q  <= 1'b0;
      start_q <= 1'b0;
      clr_q   <= 1'b0;
      fv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      gray_q  <= cnt_q ^ (cnt_q >> 1);
      done_q  <= done_d;
      start_q <= start_tgl_i;
      clr_q   <= clr_tgl_i;
      fv_q    <= fv_i;
    end
  end

  assign waddr_o   = cnt_q[AW-1:0];
  assign wdata_o   = data_i;
  assign wr_gray_o = gray_q;
  assign done_o    = done_q;

  // R4
  wr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

  // R5
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(state_q == CAP_RUN));
endmodule

// File: rtl/line_capture_buf.sv
`timescale 1ns/1ps
module line_capture_buf
  import lcb_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 11,
  parameter int STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    reg_addr_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          irq_o,
  input  logic          cam_clk_i,
  input  logic          cam_rst_ni,
  input  logic [DW-1:0] cam_data_i,
  input  logic          cam_fv_i,
  input  logic          cam_lv_i,
  input  logic          cam_dv_i,
  input  logic          cam_hs_i,
  input  logic          cam_vs_i
);
  localparam int CW = AW + 1;

  // host domain state
  logic          en_q, den_q, ien_q, irq_q;
  logic          start_tgl_q, clr_tgl_q;
  logic [CW-1:0] rd_cnt_q;
  logic          done_s, done_sq;
  logic [CW-1:0] wr_gray_s, wr_bin_s;
  logic [4:0]    live_s;
  logic          dready;
  logic          cmd_wr, cmd_clr, cmd_start, data_rd;
  logic [31:0]   stat;
  logic [DW-1:0] mem_rdata;
  logic [26:0]   unused_wdata;

  // camera domain
  logic [3:0]    ctl_s;
  logic          cam_we, cam_done;
  logic [AW-1:0] cam_waddr;
  logic [DW-1:0] cam_wdata;
  logic [CW-1:0] cam_gray;

  assign unused_wdata = reg_wdata_i[31:5];

  assign cmd_wr    = reg_we_i && reg_addr_i == REG_CMD;
  assign cmd_clr   = cmd_wr && reg_wdata_i[CMD_CLR];
  assign cmd_start = cmd_wr && reg_wdata_i[CMD_START];
  assign data_rd   = reg_re_i && reg_addr_i == REG_DATA;

  always_comb begin
    wr_bin_s[CW-1] = wr_gray_s[CW-1];
    for (int i = CW - 2; i >= 0; i--) wr_bin_s[i] = wr_bin_s[i+1] ^ wr_gray_s[i];
  end

  assign dready = (wr_bin_s != rd_cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      den_q       <= 1'b0;
      ien_q       <= 1'b0;
      irq_q       <= 1'b0;
      start_tgl_q <= 1'b0;
      clr_tgl_q   <= 1'b0;
      rd_cnt_q    <= '0;
      done_sq     <= 1'b0;
    end else begin
      done_sq <= done_s;
      if (cmd_wr) begin
        en_q  <= reg_wdata_i[CMD_EN];
        den_q <= reg_wdata_i[CMD_DEN];
        ien_q <= reg_wdata_i[CMD_IEN];
      end
      if (cmd_start) start_tgl_q <= ~start_tgl_q;
      if (cmd_clr) begin
        clr_tgl_q <= ~clr_tgl_q;
        rd_cnt_q  <= '0;
      end else if (data_rd && dready) begin
        rd_cnt_q <= rd_cnt_q + 1'b1;
      end
      if (cmd_clr || cmd_start) irq_q <= 1'b0;
      else if (done_s && !done_sq && ien_q) irq_q <= 1'b1;
    end
  end

  always_comb begin
    stat          = '0;
    stat[10:0]    = rd_cnt_q[AW-1:0];
    stat[11]      = done_s;
    stat[12]      = dready;
    stat[13]      = live_s[1];
    stat[14]      = live_s[0];
    stat[15]      = irq_q;
    stat[26:16]   = wr_bin_s[AW-1:0];
    stat[29]      = live_s[2];
    stat[30]      = live_s[3];
    stat[31]      = live_s[4];
  end

  always_comb begin
    unique case (reg_addr_i)
      REG_CMD:  reg_rdata_o = {27'd0, 1'b0, ien_q, den_q, 1'b0, en_q};
      REG_STAT: reg_rdata_o = stat;
      REG_DATA: reg_rdata_o = mem_rdata;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  lcb_sync #(.W(CW), .STAGES(STAGES)) u_sync_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cam_gray), .q_o(wr_gray_s));
  lcb_sync #(.W(1), .STAGES(STAGES)) u_sync_done (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cam_done), .q_o(done_s));
  lcb_sync #(.W(5), .STAGES(STAGES)) u_sync_live (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({cam_vs_i, cam_hs_i, cam_dv_i, cam_lv_i, cam_fv_i}), .q_o(live_s));
  lcb_sync #(.W(4), .STAGES(STAGES)) u_sync_ctl (
    .clk_i(cam_clk_i), .rst_ni(cam_rst_ni),
    .d_i({clr_tgl_q, start_tgl_q, den_q, en_q}), .q_o(ctl_s));

  lcb_cam_ctrl #(.DW(DW), .AW(AW)) u_cam_ctrl (
    .clk_i      (cam_clk_i),
    .rst_ni     (cam_rst_ni),
    .en_i       (ctl_s[0]),
    .den_i      (ctl_s[1]),
    .start_tgl_i(ctl_s[2]),
    .clr_tgl_i  (ctl_s[3]),
    .fv_i       (cam_fv_i),
    .lv_i       (cam_lv_i),
    .dv_i       (cam_dv_i),
    .data_i     (cam_data_i),
    .we_o       (cam_we),
    .waddr_o    (cam_waddr),
    .wdata_o    (cam_wdata),
    .wr_gray_o  (cam_gray),
    .done_o     (cam_done)
  );

  lcb_dpram #(.DW(DW), .AW(AW)) u_dpram (
    .wclk_i (cam_clk_i),
    .we_i   (cam_we),
    .waddr_i(cam_waddr),
    .wdata_i(cam_wdata),
    .raddr_i(rd_cnt_q[AW-1:0]),
    .rdata_o(mem_rdata)
  );

  // R9
  rd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cnt_q != $past(rd_cnt_q) && rd_cnt_q != '0) |->
      ($past(dready) && rd_cnt_q == $past(rd_cnt_q) + 1'b1));

  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(ien_q));

  // R2
  clr_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_CMD && reg_wdata_i[CMD_CLR]) |=> (rd_cnt_q == '0 && !irq_o));
endmodule

// File: tb/test_line_capture_buf.sv
`timescale 1ns/1ps
module test_line_capture_buf;
  logic        clk = 1'b0, cam_clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq;
  logic [31:0] cam_data = '0;
  logic        fv = 0, lv = 0, dv = 0, hs = 0, vs = 0;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;
  always #3 cam_clk = ~cam_clk;

  line_capture_buf i_line_capture_buf (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_re_i(reg_re), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .cam_clk_i(cam_clk), .cam_rst_ni(rst_n), .cam_data_i(cam_data),
    .cam_fv_i(fv), .cam_lv_i(lv), .cam_dv_i(dv), .cam_hs_i(hs), .cam_vs_i(vs));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic settle();
    repeat (20) @(posedge clk);
  endtask

  task automatic cam_set(input logic f, input logic l, input logic v, input logic [31:0] d);
    @(negedge cam_clk);
    fv = f; lv = l; dv = v; cam_data = d;
  endtask

  // lines of 16 cycles, data-valid low on every fifth: 13 words per line
  task automatic cam_frame(input int lines, input logic [31:0] base, input bit push);
    cam_set(1, 0, 0, 0);
    cam_set(1, 0, 0, 0);
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < 16; p++) begin
        logic [31:0] w;
        w = base + l * 32'h100 + p;
        cam_set(1, 1, (p % 5) != 4, w);
        if (push && (p % 5) != 4) exp_q.push_back(w);
      end
      cam_set(1, 0, 0, 0);
      cam_set(1, 0, 0, 0);
    end
    cam_set(0, 0, 0, 0);
    cam_set(0, 0, 0, 0);
  endtask

  // monitor: pops the scoreboard as words come out of the data register
  task automatic drain(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] got, exp;
      reg_rd(2'd2, got);
      exp = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hdead_beef;
      chk(tag, got, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] r;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    reg_rd(2'd0, r); chk("R1 cmd reset value", r, 32'h0);
    reg_rd(2'd1, r); chk("R11 status reset value", r, 32'h0);
    chk("R7 irq after reset", {31'd0, irq}, 32'h0);

    reg_wr(2'd0, 32'h0000_000D);
    reg_rd(2'd0, r); chk("R1 cmd readback", r, 32'h0000_000D);
    reg_wr(2'd0, 32'h0000_001D);
    reg_rd(2'd0, r); chk("R1 start reads 0", r, 32'h0000_000D);
    settle();

    // basic frame: 3 lines -> 39 words
    cam_frame(3, 32'h1000_0000, 1);
    settle();
    reg_rd(2'd1, r);
    chk("R5 done set", {31'd0, r[11]}, 32'd1);
    chk("R11 wr ptr field", {21'd0, r[26:16]}, 32'd39);
    chk("R11 rd ptr field", {21'd0, r[10:0]}, 32'd0);
    chk("R8 data ready", {31'd0, r[12]}, 32'd1);
    chk("R7 irq flag", {31'd0, r[15]}, 32'd1);
    chk("R7 irq pin", {31'd0, irq}, 32'd1);
    drain("R4 R9 frame data", 39);
    reg_rd(2'd1, r);
    chk("R8 empty after drain", {31'd0, r[12]}, 32'd0);
    chk("R9 rd ptr after drain", {21'd0, r[10:0]}, 32'd39);
    reg_rd(2'd2, r);
    reg_rd(2'd1, r);
    chk("R9 empty read keeps ptr", {21'd0, r[10:0]}, 32'd39);

    // clear command
    reg_wr(2'd0, 32'h0000_000F);
    settle();
    reg_rd(2'd1, r);
    chk("R2 status cleared", r, 32'h0);
    chk("R2 irq cleared", {31'd0, irq}, 32'd0);
    reg_rd(2'd0, r); chk("R1 clear reads 0", r, 32'h0000_000D);

    // start mid-frame: running frame skipped
    cam_set(1, 0, 0, 0);
    reg_wr(2'd0, 32'h0000_001D);
    settle();
    for (int p = 0; p < 8; p++) cam_set(1, 1, 1, 32'hbad0_0000 + p);
    cam_set(1, 0, 0, 0);
    settle();
    reg_rd(2'd1, r);
    chk("R3 no write before fv rise", {21'd0, r[26:16]}, 32'd0);
    chk("R3 not done mid frame", {31'd0, r[11]}, 32'd0);
    repeat (3) cam_set(0, 0, 0, 0);
    cam_frame(2, 32'h2000_0000, 1);
    settle();
    reg_rd(2'd1, r);
    chk("R3 next frame captured", {21'd0, r[26:16]}, 32'd26);
    drain("R4 second frame data", 26);

    // data enable off: nothing stored, done still set
    reg_wr(2'd0, 32'h0000_000B);
    reg_wr(2'd0, 32'h0000_0019);
    settle();
    cam_frame(1, 32'h3000_0000, 0);
    settle();
    reg_rd(2'd1, r);
    chk("R4 data enable off", {21'd0, r[26:16]}, 32'd0);
    chk("R5 done without data", {31'd0, r[11]}, 32'd1);

    // interrupt enable off
    reg_wr(2'd0, 32'h0000_0007);
    reg_wr(2'd0, 32'h0000_0015);
    settle();
    cam_frame(1, 32'h4000_0000, 1);
    settle();
    reg_rd(2'd1, r);
    chk("R7 no irq flag when disabled", {31'd0, r[15]}, 32'd0);
    chk("R7 no irq pin when disabled", {31'd0, irq}, 32'd0);
    chk("R5 done with irq off", {31'd0, r[11]}, 32'd1);
    drain("R4 third frame data", 13);

    // full buffer with concurrent draining
    reg_wr(2'd0, 32'h0000_000F);
    reg_wr(2'd0, 32'h0000_001D);
    settle();
    fork
      begin
        cam_set(1, 0, 0, 0);
        cam_set(1, 0, 0, 0);
        for (int p = 0; p < 2100; p++) begin
          cam_set(1, 1, 1, 32'h5000_0000 + p);
          if (p < 2048) exp_q.push_back(32'h5000_0000 + p);
        end
        cam_set(1, 0, 0, 0);
        cam_set(0, 0, 0, 0);
      end
      begin
        int got_n = 0;
        while (got_n < 2048) begin
          logic [31:0] s;
          reg_rd(2'd1, s);
          if (s[12]) begin
            drain("R6 R8 concurrent drain", 1);
            got_n++;
          end
        end
      end
    join
    settle();
    reg_rd(2'd1, r);
    chk("R6 wr ptr wrapped", {21'd0, r[26:16]}, 32'd0);
    chk("R6 done after full", {31'd0, r[11]}, 32'd1);
    chk("R8 no data after full drain", {31'd0, r[12]}, 32'd0);
    chk("R6 scoreboard empty", exp_q.size(), 32'd0);

    // live qualifier flags
    hs = 1; vs = 1;
    cam_set(1, 1, 1, 0);
    settle();
    reg_rd(2'd1, r);
    chk("R10 live flags high", {27'd0, r[31], r[30], r[29], r[14], r[13]}, 32'h1F);
    chk("R10 bits 27 28 zero", {30'd0, r[28:27]}, 32'd0);
    hs = 0; vs = 0;
    cam_set(0, 0, 0, 0);
    settle();
    reg_rd(2'd1, r);
    chk("R10 live flags low", {27'd0, r[31], r[30], r[29], r[14], r[13]}, 32'h0);

    summary();
  end
endmodule